// File: doc/BRIEF.md
# Fused-Operation Integer ALU

This block is a 64-bit integer execution unit for the internal operations that a decoder emits when it merges two adjacent integer instructions into one micro-op. Each operation gives, in a single step, the exact 64-bit value that the original instruction pair would have left in its destination register. That includes the rule of the 64-bit base ISA that word-format results are sign-extended from bit 31.

A dispatch stage supplies a 5-bit operation code, two 64-bit operands and a valid strobe. When the first instruction of a pair used an immediate, the immediate arrives already sign-extended on the second operand, so the unit has no immediate logic of its own. Three arithmetic groups are computed in parallel: shift-based forms, word-add forms and logic forms. Their results are merged, and an optional output register sets the latency to zero or one cycle. Any code outside the defined set gives a zero result.

Top module: `fused_alu`

## Requirements
- R1: Codes 1, 2 and 3 return bits 31:0 of src_a, zero-extended to 64 bits and then shifted left by 1, 2 or 3. This equals a left shift by 32 followed by a logical right shift by 31, 30 or 29.
- R2: Code 4 returns src_a bits 15:8 in result bits 7:0, with every higher bit zero.
- R3: Code 5 returns (src_a << 4) + src_b, wrapping modulo 2^64.
- R4: Codes 6, 7, 8 and 9 return (src_a >> k) + src_b, modulo 2^64. The shift is logical, with k equal to 29, 30, 31 and 32 respectively.
- R5: Code 10 returns src_b + (src_a & 1) as a full 64-bit sum. Code 11 takes the same sum, keeps its low 32 bits and sign-extends bit 31.
- R6: Code 12 returns src_a with bits 7:0 forced to zero, ORed with src_b.
- R7: Codes 13 to 16 first form s = src_a[31:0] + src_b[31:0] modulo 2^32. They return s[7:0] zero-extended (13), s[0] zero-extended (14), s[15:0] zero-extended (15), or s[15:0] sign-extended from bit 15 (16).
- R8: Codes 17, 18, 19 and 20 compute src_a AND src_b, src_a OR src_b, src_a XOR src_b and the byte OR-combine of src_a, respectively. Each returns only bit 0 of that value, with all other result bits zero.
- R9: Codes 21, 22, 23 and 24 compute the same four values in the same order as R8. Each returns bits 15:0 of that value, zero-extended.
- R10: The byte OR-combine used by codes 20 and 24 sets each byte of its value to 0xFF when the matching byte of src_a is nonzero, and to 0x00 otherwise.
- R11: Codes 0 and 25 to 31 give a zero result, and none of the arithmetic groups claims them.
- R12: With the output register enabled (the default), out_vld and out_res appear one clock after in_vld and op_sel are sampled. out_vld is low in the cycle after in_vld was low, and out_res keeps its last value while no new input is valid. An active-low synchronous reset clears out_vld and out_res.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 5 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (carries the sign-extended immediate for immediate forms) |
| out_vld | output | 1 | Result valid |
| out_res | output | 64 | Result |

## Verification
The bench computes each expected value by running the original instruction pair in sequence as a software model. It sweeps every code over operands built from 0, all-ones, 0x8000_0000 and 0x7FFF_FFFF, then adds pseudo-random operands. Each corner exposes a specific mistake:
- 0x7FFF_FFFF plus a small value catches a word variant that zero-extends where it should sign-extend.
- All-ones catches a scaled add or a shift-right add whose carry does not wrap at 64 bits, and a shift-right that fills with the sign bit.
- Operands with bit 31 set catch a zero-extend-then-shift that leaks upper bits of src_a.
- Operands whose nonzero bytes sit in different places catch a byte OR-combine that tests whole words instead of single bytes.
- The undefined codes catch a result mux that falls through to some group's value.
- A back-to-back pair followed by an idle cycle catches a result that fails to hold or a valid that sticks high.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;

  parameter int unsigned FA_XLEN  = 64;
  localparam int unsigned FA_HALF = FA_XLEN / 2;
  localparam int unsigned FA_BYTES = FA_XLEN / 8;
  localparam int unsigned FA_OPW  = 5;

  typedef enum logic [FA_OPW-1:0] {
    FA_OP_NONE   = 5'd0,
    FA_ZW_SL1    = 5'd1,
    FA_ZW_SL2    = 5'd2,
    FA_ZW_SL3    = 5'd3,
    FA_BYTE1     = 5'd4,
    FA_SL4_ADD   = 5'd5,
    FA_SR29_ADD  = 5'd6,
    FA_SR30_ADD  = 5'd7,
    FA_SR31_ADD  = 5'd8,
    FA_SR32_ADD  = 5'd9,
    FA_ODD_ADD   = 5'd10,
    FA_ODD_ADDW  = 5'd11,
    FA_HI_MERGE  = 5'd12,
    FA_WADD_B8   = 5'd13,
    FA_WADD_B1   = 5'd14,
    FA_WADD_ZH   = 5'd15,
    FA_WADD_SH   = 5'd16,
    FA_AND_B0    = 5'd17,
    FA_OR_B0     = 5'd18,
    FA_XOR_B0    = 5'd19,
    FA_ORCB_B0   = 5'd20,
    FA_AND_H0    = 5'd21,
    FA_OR_H0     = 5'd22,
    FA_XOR_H0    = 5'd23,
    FA_ORCB_H0   = 5'd24
  } fa_op_e;

  localparam int unsigned FA_LAST_OP = 24;

  // Word value sign-extended to the full register width.
  function automatic logic [FA_XLEN-1:0] fa_sext_word(input logic [FA_HALF-1:0] w);
    return {{FA_HALF{w[FA_HALF-1]}}, w};
  endfunction

  // Bit 0 kept, all else cleared.
  function automatic logic [FA_XLEN-1:0] fa_keep_bit0(input logic [FA_XLEN-1:0] x);
    return {{(FA_XLEN-1){1'b0}}, x[0]};
  endfunction

  // Low halfword kept, zero-extended.
  function automatic logic [FA_XLEN-1:0] fa_keep_half(input logic [FA_XLEN-1:0] x);
    return {{(FA_XLEN-16){1'b0}}, x[15:0]};
  endfunction

  // Low word zero-extended then shifted left by a small amount.
  function automatic logic [FA_XLEN-1:0] fa_zw_shl(input logic [FA_XLEN-1:0] x,
                                                   input int unsigned sh);
    return {{FA_HALF{1'b0}}, x[FA_HALF-1:0]} << sh;
  endfunction

  function automatic logic fa_is_defined(input logic [FA_OPW-1:0] op);
    return (op != 5'd0) && (int'(op) <= FA_LAST_OP);
  endfunction

  function automatic logic fa_is_bit0_op(input logic [FA_OPW-1:0] op);
    return (op == FA_WADD_B1) || ((op >= FA_AND_B0) && (op <= FA_ORCB_B0));
  endfunction

  function automatic logic fa_is_half_op(input logic [FA_OPW-1:0] op);
    return (op == FA_WADD_ZH) || ((op >= FA_AND_H0) && (op <= FA_ORCB_H0));
  endfunction

endpackage

// File: rtl/fa_shift_unit.sv
module fa_shift_unit
  import fused_alu_pkg::*;
(
  input  fa_op_e               op,
  input  logic [FA_XLEN-1:0]   src_a,
  input  logic [FA_XLEN-1:0]   src_b,
  output logic [FA_XLEN-1:0]   res,
  output logic                 hit
);

  localparam int unsigned SR_BASE = 29;
  localparam int unsigned SR_CNT  = 4;

  // One logical right-shift-and-add term per supported distance.
  logic [FA_XLEN-1:0] sr_add [SR_CNT];

  generate
    for (genvar k = 0; k < SR_CNT; k++) begin : g_sr
      assign sr_add[k] = (src_a >> (SR_BASE + k)) + src_b;
    end
  endgenerate

  always_comb begin
    res = '0;
    hit = 1'b1;
    case (op)
      FA_ZW_SL1:   res = fa_zw_shl(src_a, 1);
      FA_ZW_SL2:   res = fa_zw_shl(src_a, 2);
      FA_ZW_SL3:   res = fa_zw_shl(src_a, 3);
      FA_BYTE1:    res = {{(FA_XLEN-8){1'b0}}, src_a[15:8]};
      FA_SL4_ADD:  res = (src_a << 4) + src_b;
      FA_SR29_ADD: res = sr_add[0];
      FA_SR30_ADD: res = sr_add[1];
      FA_SR31_ADD: res = sr_add[2];
      FA_SR32_ADD: res = sr_add[3];
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fa_word_unit.sv
module fa_word_unit
  import fused_alu_pkg::*;
(
  input  fa_op_e               op,
  input  logic [FA_HALF-1:0]   src_a_lo,
  input  logic [FA_XLEN-1:0]   src_b,
  output logic [FA_XLEN-1:0]   res,
  output logic                 hit
);

  logic [FA_HALF-1:0] wsum;
  logic [FA_HALF-1:0] odd_wsum;
  logic [FA_XLEN-1:0] odd_sum;

  assign wsum     = src_a_lo + src_b[FA_HALF-1:0];
  assign odd_sum  = src_b + {{(FA_XLEN-1){1'b0}}, src_a_lo[0]};
  assign odd_wsum = src_b[FA_HALF-1:0] + {{(FA_HALF-1){1'b0}}, src_a_lo[0]};

  always_comb begin
    res = '0;
    hit = 1'b1;
    case (op)
      FA_ODD_ADD:  res = odd_sum;
      FA_ODD_ADDW: res = fa_sext_word(odd_wsum);
      FA_WADD_B8:  res = {{(FA_XLEN-8){1'b0}}, wsum[7:0]};
      FA_WADD_B1:  res = {{(FA_XLEN-1){1'b0}}, wsum[0]};
      FA_WADD_ZH:  res = {{(FA_XLEN-16){1'b0}}, wsum[15:0]};
      FA_WADD_SH:  res = {{(FA_XLEN-16){wsum[15]}}, wsum[15:0]};
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fa_logic_unit.sv
module fa_logic_unit
  import fused_alu_pkg::*;
(
  input  fa_op_e               op,
  input  logic [FA_XLEN-1:0]   src_a,
  input  logic [FA_XLEN-1:0]   src_b,
  output logic [FA_XLEN-1:0]   res,
  output logic                 hit
);

  logic [FA_XLEN-1:0] and_v;
  logic [FA_XLEN-1:0] or_v;
  logic [FA_XLEN-1:0] xor_v;
  logic [FA_XLEN-1:0] orcb_v;

  assign and_v = src_a & src_b;
  assign or_v  = src_a | src_b;
  assign xor_v = src_a ^ src_b;

  // Byte OR-combine: each byte becomes all ones if any of its bits is set.
  generate
    for (genvar g = 0; g < FA_BYTES; g++) begin : g_orcb
      assign orcb_v[8*g +: 8] = {8{|src_a[8*g +: 8]}};
    end
  endgenerate

  always_comb begin
    res = '0;
    hit = 1'b1;
    case (op)
      FA_HI_MERGE: res = {src_a[FA_XLEN-1:8], 8'h00} | src_b;
      FA_AND_B0:   res = fa_keep_bit0(and_v);
      FA_OR_B0:    res = fa_keep_bit0(or_v);
      FA_XOR_B0:   res = fa_keep_bit0(xor_v);
      FA_ORCB_B0:  res = fa_keep_bit0(orcb_v);
      FA_AND_H0:   res = fa_keep_half(and_v);
      FA_OR_H0:    res = fa_keep_half(or_v);
      FA_XOR_H0:   res = fa_keep_half(xor_v);
      FA_ORCB_H0:  res = fa_keep_half(orcb_v);
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fa_out_stage.sv
module fa_out_stage
  import fused_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [FA_XLEN-1:0]   in_res,
  output logic                 out_vld,
  output logic [FA_XLEN-1:0]   out_res
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_vld <= 1'b0;
          out_res <= '0;
        end else begin
          out_vld <= in_vld;
          if (in_vld) out_res <= in_res;
        end
      end
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign out_vld = in_vld;
      assign out_res = in_res;
    end
  endgenerate

endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fused_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [FA_OPW-1:0]    op_sel,
  input  logic [FA_XLEN-1:0]   src_a,
  input  logic [FA_XLEN-1:0]   src_b,
  output logic                 out_vld,
  output logic [FA_XLEN-1:0]   out_res
);

  localparam int unsigned N_UNITS = 3;

  fa_op_e             op;
  logic [FA_XLEN-1:0] shift_res;
  logic [FA_XLEN-1:0] word_res;
  logic [FA_XLEN-1:0] logic_res;
  logic [FA_XLEN-1:0] comb_res;
  // Which group claimed the current code; observed by the checker.
  logic [N_UNITS-1:0] unit_hit;

  assign op = fa_op_e'(op_sel);

  fa_shift_unit u_shift (
    .op    (op),
    .src_a (src_a),
    .src_b (src_b),
    .res   (shift_res),
    .hit   (unit_hit[0])
  );

  fa_word_unit u_word (
    .op       (op),
    .src_a_lo (src_a[FA_HALF-1:0]),
    .src_b    (src_b),
    .res      (word_res),
    .hit      (unit_hit[1])
  );

  fa_logic_unit u_logic (
    .op    (op),
    .src_a (src_a),
    .src_b (src_b),
    .res   (logic_res),
    .hit   (unit_hit[2])
  );

  // Groups drive zero when they do not own the code, so an OR merges them.
  assign comb_res = shift_res | word_res | logic_res;

  fa_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_res  (comb_res),
    .out_vld (out_vld),
    .out_res (out_res)
  );

endmodule

// File: rtl/fused_alu_checker.sv
module fused_alu_checker
  import fused_alu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [FA_OPW-1:0]    op_sel,
  input  logic                 out_vld,
  input  logic [FA_XLEN-1:0]   out_res,
  input  logic [2:0]           unit_hit
);

  logic              vld_d;
  logic [FA_OPW-1:0] op_d;

  generate
    if (REG_OUT) begin : g_dly
      logic              vld_q;
      logic [FA_OPW-1:0] op_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          op_q  <= '0;
        end else begin
          vld_q <= in_vld;
          if (in_vld) op_q <= op_sel;
        end
      end
      assign vld_d = vld_q;
      assign op_d  = op_q;

      a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_vld);
    end else begin : g_nodly
      assign vld_d = in_vld;
      assign op_d  = op_sel;
    end
  endgenerate

  a_r12_valid_track: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == vld_d);

  a_r11_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    fa_is_defined(op_sel) |-> $onehot(unit_hit));

  a_r11_no_group: assert property (@(posedge clk) disable iff (!rst_n)
    !fa_is_defined(op_sel) |-> (unit_hit == 3'b000));

  a_r11_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && !fa_is_defined(op_d)) |-> (out_res == '0));

  a_r8_bit0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && fa_is_bit0_op(op_d)) |-> (out_res[FA_XLEN-1:1] == '0));

  a_r9_half_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && fa_is_half_op(op_d)) |-> (out_res[FA_XLEN-1:16] == '0));

  a_r2_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && (op_d == FA_BYTE1)) |-> (out_res[FA_XLEN-1:8] == '0));

endmodule

bind fused_alu fused_alu_checker #(.REG_OUT(REG_OUT)) u_fused_alu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .op_sel   (op_sel),
  .out_vld  (out_vld),
  .out_res  (out_res),
  .unit_hit (unit_hit)
);

// File: tb/fused_alu_bench.sv
`timescale 1ns/1ps
module fused_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_vld;
  logic [63:0] out_res;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  fused_alu u_fused_alu (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .out_vld(out_vld), .out_res(out_res)
  );

  // ---- single-instruction models ----
  function automatic logic [63:0] i_slli(logic [63:0] x, int s); return x << s; endfunction
  function automatic logic [63:0] i_srli(logic [63:0] x, int s); return x >> s; endfunction
  function automatic logic [63:0] i_add(logic [63:0] x, logic [63:0] y); return x + y; endfunction
  function automatic logic [63:0] i_addw(logic [63:0] x, logic [63:0] y);
    logic [31:0] t;
    t = x[31:0] + y[31:0];
    return {{32{t[31]}}, t};
  endfunction
  function automatic logic [63:0] i_andi(logic [63:0] x, logic [11:0] imm);
    return x & {{52{imm[11]}}, imm};
  endfunction
  function automatic logic [63:0] i_zexth(logic [63:0] x); return {48'd0, x[15:0]}; endfunction
  function automatic logic [63:0] i_sexth(logic [63:0] x); return {{48{x[15]}}, x[15:0]}; endfunction
  function automatic logic [63:0] i_orcb(logic [63:0] x);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (((x >> (8*i)) & 64'hFF) != 0) r = r | (64'hFF << (8*i));
    return r;
  endfunction

  // Reference: the instruction pair executed in sequence.
  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
    case (op)
      1, 2, 3:        return i_srli(i_slli(a, 32), 32 - op);
      4:              return i_andi(i_srli(a, 8), 12'd255);
      5:              return i_add(i_slli(a, 4), b);
      6, 7, 8, 9:     return i_add(i_srli(a, op + 23), b);
      10:             return i_add(i_andi(a, 12'd1), b);
      11:             return i_addw(i_andi(a, 12'd1), b);
      12:             return i_andi(a, 12'hF00) | b;
      13:             return i_andi(i_addw(a, b), 12'd255);
      14:             return i_andi(i_addw(a, b), 12'd1);
      15:             return i_zexth(i_addw(a, b));
      16:             return i_sexth(i_addw(a, b));
      17:             return i_andi(a & b, 12'd1);
      18:             return i_andi(a | b, 12'd1);
      19:             return i_andi(a ^ b, 12'd1);
      20:             return i_andi(i_orcb(a), 12'd1);
      21:             return i_zexth(a & b);
      22:             return i_zexth(a | b);
      23:             return i_zexth(a ^ b);
      24:             return i_zexth(i_orcb(a));
      default:        return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    if (op >= 1 && op <= 3) return "R1";
    if (op == 4) return "R2";
    if (op == 5) return "R3";
    if (op >= 6 && op <= 9) return "R4";
    if (op == 10 || op == 11) return "R5";
    if (op == 12) return "R6";
    if (op >= 13 && op <= 16) return "R7";
    if (op == 20 || op == 24) return "R10";
    if (op >= 17 && op <= 19) return "R8";
    if (op >= 21 && op <= 23) return "R9";
    return "R11";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // Drive one operation, check it one cycle later (R12 latency).
  task automatic run_op(int op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    op_sel = 5'(op); src_a = a; src_b = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R12 valid", {63'd0, out_vld}, 64'd1);
    check(tag_of(op), out_res, model(op, a, b));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset valid", {63'd0, out_vld}, 64'd0);
    check("R12 reset result", out_res, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_edges();
    logic [63:0] e [4];
    e[0] = 64'd0; e[1] = '1; e[2] = 64'h8000_0000; e[3] = 64'h7FFF_FFFF;
    for (int op = 1; op <= 24; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run_op(op, e[i], e[j]);
  endtask

  task automatic t_random();
    for (int n = 0; n < 20; n++)
      for (int op = 1; op <= 24; op++)
        run_op(op, next_rand(), next_rand());
  endtask

  // R10: nonzero bytes in scattered positions.
  task automatic t_orcb_bytes();
    run_op(24, 64'h0000_0100_0000_8001, 64'd0);
    run_op(24, 64'h0100_0000_0000_0000, 64'd0);
    run_op(20, 64'h0000_0000_0000_0100, 64'd0);
    run_op(20, 64'h0000_0000_0000_0010, 64'd0);
  endtask

  task automatic t_undefined();
    run_op(0, '1, '1);  // R11
    for (int op = 25; op <= 31; op++) run_op(op, '1, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    op_sel = 5'd5; src_a = 64'd1; src_b = 64'd2; in_vld = 1'b1;
    @(negedge clk);
    check("R12 b2b first", out_res, 64'd18);
    op_sel = 5'd10; src_a = 64'd3; src_b = 64'd4;
    @(negedge clk);
    check("R12 b2b second", out_res, 64'd5);
    check("R12 b2b valid", {63'd0, out_vld}, 64'd1);
    in_vld = 1'b0; op_sel = 5'd12; src_a = '1;
    @(negedge clk);
    check("R12 idle valid", {63'd0, out_vld}, 64'd0);
    check("R12 hold result", out_res, 64'd5);
    // reset while a valid input is presented
    in_vld = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset over valid", {63'd0, out_vld}, 64'd0);
    in_vld = 1'b0; rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pipeline();
    t_edges();
    t_orcb_bytes();
    t_undefined();
    t_random();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule